// File: doc/BRIEF.md
# Packed SIMD Saturating DSP ALU

This unit is a single-cycle arithmetic slice for a signal-processing datapath. It takes two 32-bit operand words and a 32-bit accumulator word, and an opcode picks the operation. The operations are lane-parallel clamped add and subtract on byte lanes, halfword lanes or the whole word; halving adds, signed or unsigned, on byte or halfword lanes; a dual 16x16 signed product difference added to the accumulator; and a clamp to a programmable signed width, with an optional shift before the clamp. The result path is purely combinational.

The only state is a sticky overflow indicator. Any clamping event, or accumulator overflow in the dual-product mode, sets it on the following clock edge. It stays set until the surrounding logic pulses the clear input.

Top module: `simd_dsp_alu`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (subtract) treat each operand as four signed 8-bit lanes, byte i in bits 8i+7..8i. Each lane result is clamped to -128..127 and does not wrap.
- R2: Opcode 2 (add) and opcode 3 (subtract) work on two signed 16-bit lanes, each clamped to -32768..32767.
- R3: Opcode 4 (add) and opcode 5 (subtract) work on the whole signed 32-bit word, clamped to -2^31..2^31-1.
- R4: Opcode 6 (byte lanes) and opcode 8 (halfword lanes) give, in each lane, the signed sum of the matching lanes halved with rounding toward minus infinity. No lane ever overflows.
- R5: Opcode 7 (byte lanes) and opcode 9 (halfword lanes) give, in each lane, the unsigned sum of the matching lanes halved, with the carry kept.
- R6: Opcode 10 returns acc + a[15:0]*b[15:0] - a[31:16]*b[31:16], all signed, wrapped modulo 2^32. The unit flags an overflow when the exact value does not fit in 32 signed bits.
- R7: Opcode 11 shifts a, then clamps it to N = sat_pos+1 signed bits, range -2^(N-1)..2^(N-1)-1. The shift is logical left by shamt when sh_right is 0 and arithmetic right by shamt when sh_right is 1. A clamp counts as a saturation.
- R8: On the clock edge after any saturation in opcodes 0-5 or 11, or an overflow in opcode 10, sat_flag reads 1. Halving opcodes 6-9 never set it.
- R9: sat_flag holds its value until sat_clr is high at a clock edge with no new saturation in that cycle. If a saturation occurs in the same cycle as the clear, the flag stays set. An active-low reset clears it at once.
- R10: Opcodes 12-15 return 0 and never set sat_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| sat_clr | input | 1 | Clears the sticky flag at the next edge |
| op | input | 4 | Operation select |
| a | input | 32 | First operand word |
| b | input | 32 | Second operand word |
| acc | input | 32 | Accumulator input for the dual-product mode |
| sat_pos | input | 5 | Clamp width minus one for opcode 11 |
| shamt | input | 5 | Pre-clamp shift amount for opcode 11 |
| sh_right | input | 1 | Pre-clamp shift direction, 1 = arithmetic right |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The hardest case to reach from the ports is the dual-product overflow. Both halfword products must be near their extremes with opposite signs, and the accumulator must already sit near a 32-bit bound. The stimulus therefore pairs -32768 x -32768 in the low halves with 32767 x -32768 in the high halves, against accumulators of 0x7FFFFFFF and 0. A second hard case is a clear that arrives in the same cycle as a new saturation. The flag sequence drives both together and reads the flag on the following cycle.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   typedef enum logic [3:0] {
      OP_QADD8    = 4'd0,
      OP_QSUB8    = 4'd1,
      OP_QADD16   = 4'd2,
      OP_QSUB16   = 4'd3,
      OP_QADD32   = 4'd4,
      OP_QSUB32   = 4'd5,
      OP_SHADD8   = 4'd6,
      OP_UHADD8   = 4'd7,
      OP_SHADD16  = 4'd8,
      OP_UHADD16  = 4'd9,
      OP_DUAL_MSD = 4'd10,
      OP_CLAMP    = 4'd11,
      OP_RSV12    = 4'd12,
      OP_RSV13    = 4'd13,
      OP_RSV14    = 4'd14,
      OP_RSV15    = 4'd15
   } alu_op_e;

   localparam int NUM_SAT_GROUPS  = 3;
   localparam int NUM_HALF_GROUPS = 2;

endpackage

// File: rtl/simd_satadd_lanes.sv
module simd_satadd_lanes #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] y,
   output logic              sat
);
   localparam int N_LANES = DATA_W / LANE_W;

   logic [N_LANES-1:0] lane_sat;

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      logic signed [LANE_W:0]   ext_a, ext_b, sum;
      logic        [LANE_W-1:0] lane_y;
      logic                     lane_ovf;

      always_comb begin
         ext_a    = {a[i*LANE_W+LANE_W-1], a[i*LANE_W +: LANE_W]};
         ext_b    = {b[i*LANE_W+LANE_W-1], b[i*LANE_W +: LANE_W]};
         sum      = sub ? (ext_a - ext_b) : (ext_a + ext_b);
         lane_ovf = sum[LANE_W] ^ sum[LANE_W-1];
         if (!lane_ovf)
            lane_y = sum[LANE_W-1:0];
         else if (sum[LANE_W])
            lane_y = {1'b1, {(LANE_W-1){1'b0}}};
         else
            lane_y = {1'b0, {(LANE_W-1){1'b1}}};
      end

      assign y[i*LANE_W +: LANE_W] = lane_y;
      assign lane_sat[i]           = lane_ovf;
   end

   assign sat = |lane_sat;

endmodule

// File: rtl/simd_halfadd_lanes.sv
module simd_halfadd_lanes #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              is_signed,
   output logic [DATA_W-1:0] y
);
   localparam int N_LANES = DATA_W / LANE_W;

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      logic [LANE_W:0] ext_a, ext_b, sum;

      always_comb begin
         ext_a = {is_signed & a[i*LANE_W+LANE_W-1], a[i*LANE_W +: LANE_W]};
         ext_b = {is_signed & b[i*LANE_W+LANE_W-1], b[i*LANE_W +: LANE_W]};
         sum   = ext_a + ext_b;
      end

      assign y[i*LANE_W +: LANE_W] = sum[LANE_W:1];
   end

endmodule

// File: rtl/simd_dual_msd.sv
module simd_dual_msd #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] y,
   output logic              ovf
);
   localparam int HALF_W = DATA_W / 2;
   localparam int TOT_W  = DATA_W + 2;
   localparam int TOP_W  = TOT_W - DATA_W + 1;

   logic signed [DATA_W-1:0] a_lo, b_lo, a_hi, b_hi, p_lo, p_hi;
   logic signed [TOT_W-1:0]  diff, total;
   logic        [TOP_W-1:0]  top_bits;

   always_comb begin
      a_lo     = DATA_W'($signed(a[HALF_W-1:0]));
      b_lo     = DATA_W'($signed(b[HALF_W-1:0]));
      a_hi     = DATA_W'($signed(a[DATA_W-1:HALF_W]));
      b_hi     = DATA_W'($signed(b[DATA_W-1:HALF_W]));
      p_lo     = a_lo * b_lo;
      p_hi     = a_hi * b_hi;
      diff     = TOT_W'(p_lo) - TOT_W'(p_hi);
      total    = diff + TOT_W'($signed(acc));
      top_bits = total[TOT_W-1:DATA_W-1];
      ovf      = ~((&top_bits) | ~(|top_bits));
      y        = total[DATA_W-1:0];
   end

endmodule

// File: rtl/simd_clamp_unit.sv
module simd_clamp_unit #(
   parameter int DATA_W = 32,
   parameter int POS_W  = 5
) (
   input  logic [DATA_W-1:0] a,
   input  logic [POS_W-1:0]  pos,
   input  logic [POS_W-1:0]  shamt,
   input  logic              sh_right,
   output logic [DATA_W-1:0] y,
   output logic              sat
);
   logic signed [DATA_W-1:0] shifted;
   logic        [DATA_W:0]   unit;
   logic signed [DATA_W:0]   lim_hi, lim_lo, wide;

   always_comb begin
      if (sh_right)
         shifted = $signed(a) >>> shamt;
      else
         shifted = $signed(a << shamt);
      unit   = {{DATA_W{1'b0}}, 1'b1} << pos;
      lim_hi = $signed(unit - {{DATA_W{1'b0}}, 1'b1});
      lim_lo = -$signed(unit);
      wide   = $signed({shifted[DATA_W-1], shifted});
      if (wide > lim_hi) begin
         y   = lim_hi[DATA_W-1:0];
         sat = 1'b1;
      end else if (wide < lim_lo) begin
         y   = lim_lo[DATA_W-1:0];
         sat = 1'b1;
      end else begin
         y   = shifted;
         sat = 1'b0;
      end
   end

endmodule

// File: rtl/simd_dsp_alu.sv
module simd_dsp_alu #(
   parameter int DATA_W = 32,
   parameter int OP_W   = 4,
   parameter int POS_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sat_clr,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] acc,
   input  logic [POS_W-1:0]  sat_pos,
   input  logic [POS_W-1:0]  shamt,
   input  logic              sh_right,
   output logic [DATA_W-1:0] result,
   output logic              sat_flag
);
   import simd_alu_pkg::*;

   localparam int BYTE_W = 8;
   localparam int HW_W   = 16;

   if (DATA_W != 2 * HW_W) begin : g_bad_width
      $error("simd_dsp_alu: DATA_W must be twice the halfword width");
   end
   if (OP_W != 4) begin : g_bad_op
      $error("simd_dsp_alu: OP_W must be 4");
   end
   if (POS_W != $clog2(DATA_W)) begin : g_bad_pos
      $error("simd_dsp_alu: POS_W must match DATA_W");
   end

   alu_op_e opc;
   assign opc = alu_op_e'(op);

   logic [DATA_W-1:0] sat_y  [NUM_SAT_GROUPS];
   logic              sat_f  [NUM_SAT_GROUPS];
   logic [DATA_W-1:0] half_y [NUM_HALF_GROUPS];
   logic [DATA_W-1:0] msd_y, clamp_y;
   logic              msd_ovf, clamp_sat, sat_any;

   for (genvar k = 0; k < NUM_SAT_GROUPS; k++) begin : g_sat
      localparam int LW = (k == 0) ? BYTE_W : ((k == 1) ? HW_W : DATA_W);
      simd_satadd_lanes #(.DATA_W(DATA_W), .LANE_W(LW)) u_lanes (
         .a   (a),
         .b   (b),
         .sub (op[0]),
         .y   (sat_y[k]),
         .sat (sat_f[k])
      );
   end

   for (genvar k = 0; k < NUM_HALF_GROUPS; k++) begin : g_half
      localparam int LW = (k == 0) ? BYTE_W : HW_W;
      logic sgn;
      assign sgn = (k == 0) ? (opc == OP_SHADD8) : (opc == OP_SHADD16);
      simd_halfadd_lanes #(.DATA_W(DATA_W), .LANE_W(LW)) u_lanes (
         .a         (a),
         .b         (b),
         .is_signed (sgn),
         .y         (half_y[k])
      );
   end

   simd_dual_msd #(.DATA_W(DATA_W)) u_msd (
      .a   (a),
      .b   (b),
      .acc (acc),
      .y   (msd_y),
      .ovf (msd_ovf)
   );

   simd_clamp_unit #(.DATA_W(DATA_W), .POS_W(POS_W)) u_clamp (
      .a        (a),
      .pos      (sat_pos),
      .shamt    (shamt),
      .sh_right (sh_right),
      .y        (clamp_y),
      .sat      (clamp_sat)
   );

   always_comb begin
      result  = '0;
      sat_any = 1'b0;
      case (opc)
         OP_QADD8, OP_QSUB8: begin
            result  = sat_y[0];
            sat_any = sat_f[0];
         end
         OP_QADD16, OP_QSUB16: begin
            result  = sat_y[1];
            sat_any = sat_f[1];
         end
         OP_QADD32, OP_QSUB32: begin
            result  = sat_y[2];
            sat_any = sat_f[2];
         end
         OP_SHADD8, OP_UHADD8:   result = half_y[0];
         OP_SHADD16, OP_UHADD16: result = half_y[1];
         OP_DUAL_MSD: begin
            result  = msd_y;
            sat_any = msd_ovf;
         end
         OP_CLAMP: begin
            result  = clamp_y;
            sat_any = clamp_sat;
         end
         default: begin
            result  = '0;
            sat_any = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sat_flag <= 1'b0;
      else
         sat_flag <= (sat_flag & ~sat_clr) | sat_any;
   end

endmodule

// File: rtl/simd_dsp_alu_chk.sv
module simd_dsp_alu_chk #(
   parameter int DATA_W = 32,
   parameter int OP_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sat_clr,
   input logic [OP_W-1:0]   op,
   input logic [DATA_W-1:0] a,
   input logic [DATA_W-1:0] b,
   input logic [DATA_W-1:0] result,
   input logic              sat_flag,
   input logic              sat_any
);

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      sat_any |=> sat_flag);  // R8

   AST_HALVING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (op >= 4'd6 && op <= 4'd9) |-> !sat_any);  // R8

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clr) |=> sat_flag);  // R9

   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clr && !sat_any) |=> !sat_flag);  // R9

   AST_WORD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 4'd4 && !sat_any) |-> (result == a + b));  // R3

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op >= 4'd12) |-> (result == '0 && !sat_any));  // R10

endmodule

bind simd_dsp_alu simd_dsp_alu_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sat_clr  (sat_clr),
   .op       (op),
   .a        (a),
   .b        (b),
   .result   (result),
   .sat_flag (sat_flag),
   .sat_any  (sat_any)
);

// File: tb/simd_dsp_alu_tb.sv
`timescale 1ns/1ps
module simd_dsp_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sat_clr = 1'b0;
   logic [3:0]  op = 4'd12;
   logic [31:0] a = '0, b = '0, acc = '0;
   logic [4:0]  sat_pos = '0, shamt = '0;
   logic        sh_right = 1'b0;
   logic [31:0] result;
   logic        sat_flag;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   simd_dsp_alu u_dut (
      .clk(clk), .rst_n(rst_n), .sat_clr(sat_clr), .op(op),
      .a(a), .b(b), .acc(acc), .sat_pos(sat_pos), .shamt(shamt),
      .sh_right(sh_right), .result(result), .sat_flag(sat_flag)
   );

   function automatic longint sx(input logic [31:0] v, input int lo, input int w);
      longint x;
      x = longint'((v >> lo) & ((64'd1 << w) - 1));
      if (x >= (longint'(1) << (w - 1))) x = x - (longint'(1) << w);
      return x;
   endfunction

   function automatic longint ux(input logic [31:0] v, input int lo, input int w);
      return longint'((v >> lo) & ((64'd1 << w) - 1));
   endfunction

   function automatic logic [31:0] ref_alu(input int o, input logic [31:0] ia, ib, iacc,
                                           input int p, input int s, input bit rt,
                                           output bit sat);
      logic [31:0] r;
      longint v, mx, mn;
      int w;
      r = '0;
      sat = 0;
      if (o <= 5) begin
         w = (o < 2) ? 8 : ((o < 4) ? 16 : 32);
         mx = (longint'(1) << (w - 1)) - 1;
         mn = -(longint'(1) << (w - 1));
         for (int i = 0; i < 32 / w; i++) begin
            v = (o % 2 == 1) ? sx(ia, i*w, w) - sx(ib, i*w, w) : sx(ia, i*w, w) + sx(ib, i*w, w);
            if (v > mx) begin v = mx; sat = 1; end
            if (v < mn) begin v = mn; sat = 1; end
            r = r | (32'(v & ((64'd1 << w) - 1)) << (i*w));
         end
      end else if (o <= 9) begin
         w = (o < 8) ? 8 : 16;
         for (int i = 0; i < 32 / w; i++) begin
            if (o == 6 || o == 8) v = (sx(ia, i*w, w) + sx(ib, i*w, w)) >>> 1;
            else v = (ux(ia, i*w, w) + ux(ib, i*w, w)) >> 1;
            r = r | (32'(v & ((64'd1 << w) - 1)) << (i*w));
         end
      end else if (o == 10) begin
         v = sx(ia, 0, 16) * sx(ib, 0, 16) - sx(ia, 16, 16) * sx(ib, 16, 16) + sx(iacc, 0, 32);
         sat = (v > 64'sd2147483647) || (v < -64'sd2147483648);
         r = v[31:0];
      end else if (o == 11) begin
         if (rt) v = sx(ia, 0, 32) >>> s;
         else v = sx(ia << s, 0, 32);
         mx = (longint'(1) << p) - 1;
         mn = -(longint'(1) << p);
         if (v > mx) begin v = mx; sat = 1; end
         if (v < mn) begin v = mn; sat = 1; end
         r = v[31:0];
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input string tag, input int o, input logic [31:0] ia, ib, iacc,
                       input int p, input int s, input bit rt, input bit clr);
      bit es;
      logic [31:0] exp;
      @(negedge clk);
      op = 4'(o); a = ia; b = ib; acc = iacc;
      sat_pos = 5'(p); shamt = 5'(s); sh_right = rt; sat_clr = clr;
      #2;
      exp = ref_alu(o, ia, ib, iacc, p, s, rt, es);
      check(tag, result, exp);
   endtask

   task automatic chk_flag(input string tag, input bit exp);
      @(negedge clk);
      #2;
      check(tag, {31'b0, sat_flag}, {31'b0, exp});
   endtask

   task automatic t_reset;
      #3;
      check("R9 reset flag", {31'b0, sat_flag}, 32'd0);
      check("R10 reset result", result, 32'd0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_bytes;
      step("R1 add8 clamp", 0, 32'h7F801050, 32'h01FF20F0, 0, 0, 0, 0, 0);
      step("R1 add8 plain", 0, 32'h10203040, 32'h01020304, 0, 0, 0, 0, 0);
      step("R1 sub8 clamp", 1, 32'h807F0005, 32'h01FF0006, 0, 0, 0, 0, 0);
   endtask

   task automatic t_halves;
      step("R2 add16 clamp", 2, 32'h7FFF8000, 32'h00018000, 0, 0, 0, 0, 0);
      step("R2 sub16 clamp", 3, 32'h80007FFF, 32'h0001FFFF, 0, 0, 0, 0, 0);
      step("R2 add16 plain", 2, 32'h12340100, 32'h0001FF00, 0, 0, 0, 0, 0);
   endtask

   task automatic t_word;
      step("R3 add32 clamp hi", 4, 32'h7FFFFFFF, 32'h00000001, 0, 0, 0, 0, 0);
      step("R3 add32 clamp lo", 4, 32'h80000000, 32'h80000000, 0, 0, 0, 0, 0);
      step("R3 sub32 clamp", 5, 32'h80000000, 32'h00000001, 0, 0, 0, 0, 0);
      step("R3 sub32 plain", 5, 32'h00001000, 32'h00002000, 0, 0, 0, 0, 0);
   endtask

   task automatic t_halving;
      step("R4 shadd8", 6, 32'h807F01FF, 32'h807F0000, 0, 0, 0, 0, 0);
      step("R4 shadd16", 8, 32'h80007FFF, 32'h80000000, 0, 0, 0, 0, 0);
      step("R5 uhadd8", 7, 32'hFFFF0180, 32'hFF010180, 0, 0, 0, 0, 0);
      step("R5 uhadd16", 9, 32'hFFFF8000, 32'hFFFF0001, 0, 0, 0, 0, 0);
   endtask

   task automatic t_msd;
      step("R6 msd plain", 10, 32'h00030004, 32'h00050006, 32'h00000064, 0, 0, 0, 0);
      step("R6 msd overflow", 10, 32'h7FFF8000, 32'h80008000, 32'h7FFFFFFF, 0, 0, 0, 0);
      step("R6 msd extremes", 10, 32'h80008000, 32'h80008000, 32'h00000000, 0, 0, 0, 0);
      step("R6 msd wrap neg", 10, 32'h80000001, 32'h7FFF0001, 32'h80000000, 0, 0, 0, 0);
   endtask

   task automatic t_clamp;
      step("R7 clamp8 hi", 11, 32'd300, 0, 0, 7, 0, 0, 0);
      step("R7 clamp8 lo", 11, -32'sd300, 0, 0, 7, 0, 0, 0);
      step("R7 clamp32 pass", 11, 32'h80000000, 0, 0, 31, 0, 0, 0);
      step("R7 clamp1", 11, 32'd5, 0, 0, 0, 0, 0, 0);
      step("R7 shl then clamp", 11, 32'h10, 0, 0, 7, 4, 0, 0);
      step("R7 asr then pass", 11, 32'hFFFFF000, 0, 0, 15, 4, 1, 0);
   endtask

   task automatic t_flag;
      step("R9 clear", 4, 32'd1, 32'd2, 0, 0, 0, 0, 1);
      chk_flag("R9 cleared", 0);
      step("R8 halving extremes", 8, 32'h7FFF8000, 32'h7FFF8000, 0, 0, 0, 0, 0);
      chk_flag("R8 halving no flag", 0);
      step("R10 reserved op", 13, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, 0, 0, 0);
      chk_flag("R10 reserved no flag", 0);
      step("R8 sat sets", 0, 32'h7F000000, 32'h7F000000, 0, 0, 0, 0, 0);
      chk_flag("R8 flag set", 1);
      step("R9 sticky", 0, 32'h01010101, 32'h01010101, 0, 0, 0, 0, 0);
      chk_flag("R9 flag held", 1);
      step("R9 clr+sat", 2, 32'h7FFF0000, 32'h7FFF0000, 0, 0, 0, 0, 1);
      chk_flag("R9 clr loses to sat", 1);
      step("R9 clear again", 9, 32'd1, 32'd1, 0, 0, 0, 0, 1);
      chk_flag("R9 cleared again", 0);
      step("R6 overflow sets", 10, 32'h7FFF8000, 32'h80008000, 32'h7FFFFFFF, 0, 0, 0, 0);
      chk_flag("R6 flag after overflow", 1);
      step("R9 clear 3", 4, 0, 0, 0, 0, 0, 0, 1);
      chk_flag("R9 cleared 3", 0);
      step("R7 clamp sets", 11, 32'd300, 0, 0, 7, 0, 0, 0);
      chk_flag("R7 flag after clamp", 1);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R9 async reset", {31'b0, sat_flag}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_bytes();
      t_halves();
      t_word();
      t_halving();
      t_msd();
      t_clamp();
      t_flag();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule